// File: doc/BRIEF.md
# Transition-Filtered Status Register Group

This block turns a vector of live condition bits into latched status events. Every bit has its own edge qualifier. One mask selects rising changes and a second selects falling changes. A qualified change sets the matching bit of a sticky event register. That bit stays set until software reads the event register or pulses clear-status. The latched events are gated by an enable mask and reduced to a single summary flag, which a higher-level status byte can consume.

The host side is a small flat register port. It has one address bus, a write strobe, a read strobe and combinational read data. Through it the host programs the three masks, inspects the live condition and collects events with a read that clears them. A preset pulse returns the masks to their default qualifying set. A clear-status pulse empties only the event register.

Top module: `stat_xfilt_group`

## Requirements
- R1: When rise-mask bit i is 1, a condition bit i that is 0 on one cycle and 1 on the next sets event bit i at that clock edge.
- R2: When fall-mask bit i is 1, a condition bit i that is 1 on one cycle and 0 on the next sets event bit i at that clock edge.
- R3: With rise and fall bits both 1, any change of condition bit i sets event bit i. With both 0, no change of bit i ever sets event bit i.
- R4: Event bits are sticky. Once set, a bit stays 1 whatever the condition does afterwards, until an event read or a clear-status.
- R5: A read strobe at address 4 returns the event value in that cycle and clears the register at the edge. A qualifying edge in the same cycle still leaves its bit set.
- R6: summary_o is the OR of (event AND enable). It rises in the cycle after the event bit latches.
- R7: A preset pulse sets every rise bit to 1 and clears every fall bit and every enable bit at the edge. The event register is left unchanged. Preset takes priority over a write in the same cycle.
- R8: A clear-status pulse clears the event register and leaves the enable register unchanged.
- R9: The address map is 0 live condition (read-only), 1 rise mask, 2 fall mask, 3 enable, 4 event (read-only, read clears). Read data is the binary-weighted register value: for example, bits 2 and 4 read as 20. Writes to addresses 0 and 4 change nothing. Addresses 5 to 7 read 0.
- R10: After reset the rise mask is all ones, and the fall mask, enable and event are zero. The stored previous condition sample is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | W | Live condition bits |
| preset_i | input | 1 | Restore mask defaults |
| clr_status_i | input | 1 | Clear the event register |
| wr_en_i | input | 1 | Write strobe for addr_i |
| rd_en_i | input | 1 | Read strobe; at address 4 it clears the events |
| addr_i | input | 3 | Register address |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Combinational read data for addr_i |
| summary_o | output | 1 | OR of enabled event bits |

## Verification
A wrong previous-sample register shows up one edge later. The event read then contains bits for changes that never happened, or misses changes that did. A sweep over every mask pair and every flip pattern exposes this on the first affected trial. A corrupt event or enable register is visible at once on rdata_o and within one cycle on summary_o. A lost same-cycle edge or a wrongly cleared enable shows on the next read of that address.

// File: rtl/sxf_pkg.sv
package sxf_pkg;
  localparam int unsigned SXF_AW = 3;
  typedef enum logic [SXF_AW-1:0] {
    SXF_COND = 3'd0,
    SXF_RISE = 3'd1,
    SXF_FALL = 3'd2,
    SXF_ENAB = 3'd3,
    SXF_EVNT = 3'd4
  } sxf_addr_e;
endpackage

// File: rtl/sxf_edge_filter.sv
module sxf_edge_filter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;

  function automatic logic [W-1:0] qualify(input logic [W-1:0] now,
                                           input logic [W-1:0] was,
                                           input logic [W-1:0] up_m,
                                           input logic [W-1:0] dn_m);
    logic [W-1:0] ups;
    logic [W-1:0] dns;
    ups = now & ~was;
    dns = was & ~now;
    return (ups & up_m) | (dns & dn_m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cond_i;
  end

  assign hit_o = qualify(cond_i, prev_q, rise_i, fall_i);
endmodule

// File: rtl/sxf_mask_regs.sv
module sxf_mask_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preset_i,
  input  logic         wr_rise_i,
  input  logic         wr_fall_i,
  input  logic         wr_enab_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] enab_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_o <= '1;
      fall_o <= '0;
      enab_o <= '0;
    end else if (preset_i) begin
      rise_o <= '1;
      fall_o <= '0;
      enab_o <= '0;
    end else begin
      if (wr_rise_i) rise_o <= wdata_i;
      if (wr_fall_i) fall_o <= wdata_i;
      if (wr_enab_i) enab_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sxf_event_latch.sv
module sxf_event_latch #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit_i,
  input  logic         clr_i,
  output logic [W-1:0] event_o
);
  function automatic logic [W-1:0] next_events(input logic [W-1:0] cur,
                                               input logic [W-1:0] hits,
                                               input logic         wipe);
    logic [W-1:0] kept;
    kept = wipe ? '0 : cur;
    return kept | hits;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_o <= '0;
    else        event_o <= next_events(event_o, hit_i, clr_i);
  end
endmodule

// File: rtl/stat_xfilt_group.sv
module stat_xfilt_group
  import sxf_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      cond_i,
  input  logic              preset_i,
  input  logic              clr_status_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [SXF_AW-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              summary_o
);
  sxf_addr_e    sel;
  logic [W-1:0] edge_hit;
  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;
  logic [W-1:0] enab_q;
  logic [W-1:0] event_q;
  logic         evt_read;
  logic         evt_clr;
  logic         wr_rise;
  logic         wr_fall;
  logic         wr_enab;

  assign sel      = sxf_addr_e'(addr_i);
  assign wr_rise  = wr_en_i && (sel == SXF_RISE);
  assign wr_fall  = wr_en_i && (sel == SXF_FALL);
  assign wr_enab  = wr_en_i && (sel == SXF_ENAB);
  assign evt_read = rd_en_i && (sel == SXF_EVNT);
  assign evt_clr  = evt_read || clr_status_i;

  sxf_edge_filter #(.W(W)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cond_i (cond_i),
    .rise_i (rise_q),
    .fall_i (fall_q),
    .hit_o  (edge_hit)
  );

  sxf_mask_regs #(.W(W)) u_masks (
    .clk       (clk),
    .rst_n     (rst_n),
    .preset_i  (preset_i),
    .wr_rise_i (wr_rise),
    .wr_fall_i (wr_fall),
    .wr_enab_i (wr_enab),
    .wdata_i   (wdata_i),
    .rise_o    (rise_q),
    .fall_o    (fall_q),
    .enab_o    (enab_q)
  );

  sxf_event_latch #(.W(W)) u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (edge_hit),
    .clr_i   (evt_clr),
    .event_o (event_q)
  );

  always_comb begin
    unique case (sel)
      SXF_COND: rdata_o = cond_i;
      SXF_RISE: rdata_o = rise_q;
      SXF_FALL: rdata_o = fall_q;
      SXF_ENAB: rdata_o = enab_q;
      SXF_EVNT: rdata_o = event_q;
      default:  rdata_o = '0;
    endcase
  end

  assign summary_o = |(event_q & enab_q);
endmodule

// File: rtl/sxf_checker.sv
module sxf_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         preset_i,
  input logic         clr_status_i,
  input logic         wr_en_i,
  input logic [2:0]   addr_i,
  input logic [W-1:0] edge_hit,
  input logic         evt_clr,
  input logic [W-1:0] event_q,
  input logic [W-1:0] rise_q,
  input logic [W-1:0] fall_q,
  input logic [W-1:0] enab_q,
  input logic         summary_o
);
  // R1 / R2: any qualified edge lands in the event register one edge later
  assert_edge_latched_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((event_q & $past(edge_hit)) == $past(edge_hit)));

  // R3: a bit with neither qualifier never produces a hit
  assert_no_unqualified_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & ~(rise_q | fall_q)) == '0));

  // R4: without a clear, no event bit falls
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_clr |=> ((event_q & $past(event_q)) == $past(event_q)));

  // R5: a clear with no hits empties the register
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && edge_hit == '0) |=> (event_q == '0));

  // R6: clear-status without hits drops the summary
  assert_summary_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status_i && edge_hit == '0) |=> !summary_o);

  // R7: preset restores the mask defaults
  assert_preset_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_i |=> (rise_q == '1 && fall_q == '0 && enab_q == '0));

  // R8: clear-status leaves enable alone
  assert_clr_keeps_enab_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status_i && !preset_i && !(wr_en_i && addr_i == 3'd3)) |=> $stable(enab_q));
endmodule

bind stat_xfilt_group sxf_checker #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .preset_i     (preset_i),
  .clr_status_i (clr_status_i),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .edge_hit     (edge_hit),
  .evt_clr      (evt_clr),
  .event_q      (event_q),
  .rise_q       (rise_q),
  .fall_q       (fall_q),
  .enab_q       (enab_q),
  .summary_o    (summary_o)
);

// File: tb/tb_stat_xfilt_group.sv
`timescale 1ns/1ps
module tb_stat_xfilt_group;
  localparam int W = 4;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cond_i = '0;
  logic         preset_i = 1'b0;
  logic         clr_status_i = 1'b0;
  logic         wr_en_i = 1'b0;
  logic         rd_en_i = 1'b0;
  logic [2:0]   addr_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic         summary_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stat_xfilt_group #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond_i), .preset_i(preset_i),
    .clr_status_i(clr_status_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .summary_o(summary_o)
  );

  function automatic logic [W-1:0] expect_hits(logic [W-1:0] was, logic [W-1:0] now,
                                               logic [W-1:0] up, logic [W-1:0] dn);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (up[i] && !was[i] && now[i]) r[i] = 1'b1;
      if (dn[i] && was[i] && !now[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, string req, int exp);
    addr_i = a;
    #1;
    check(req, int'(rdata_o), exp);
  endtask

  task automatic clr_status();
    clr_status_i = 1'b1;
    step();
    clr_status_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset values
    peek(3'd1, "R10 rise reset", 15);
    peek(3'd2, "R10 fall reset", 0);
    peek(3'd3, "R10 enab reset", 0);
    peek(3'd4, "R10 event reset", 0);
    check("R10 summary reset", int'(summary_o), 0);

    // R9: weighted readback and map
    wr(3'd3, 4'd0); wr(3'd1, 4'd5);
    peek(3'd1, "R9 rise readback", 5);
    wr(3'd1, ONES);
    cond_i = 4'b1010; step();
    peek(3'd0, "R9 live condition", 10);
    peek(3'd5, "R9 unmapped reads 0", 0);
    peek(3'd4, "R1 rising bits", 10);
    wr(3'd0, 4'd3);
    peek(3'd0, "R9 cond write ignored", 10);
    wr(3'd4, 4'd5);
    peek(3'd4, "R9 event write ignored", 10);

    // R4: sticky although condition falls back with fall mask 0
    cond_i = 4'b0000; step(); step();
    peek(3'd4, "R4 sticky after fall", 10);

    // R6: summary gating and timing
    wr(3'd3, 4'b0100);
    check("R6 summary masked off", int'(summary_o), 0);
    wr(3'd3, 4'b0010);
    check("R6 summary on", int'(summary_o), 1);

    // R8: clear-status empties events, keeps enable
    clr_status();
    peek(3'd4, "R8 events cleared", 0);
    peek(3'd3, "R8 enable kept", 2);
    check("R6 summary after clear", int'(summary_o), 0);
    cond_i = 4'b0010;
    addr_i = 3'd0;
    #1;
    check("R6 summary not before edge", int'(summary_o), 0);
    step();
    check("R6 summary after latch", int'(summary_o), 1);

    // R5: read clears; same-cycle edge survives
    addr_i = 3'd4; rd_en_i = 1'b1;
    #1;
    check("R5 read value", int'(rdata_o), 2);
    step();
    rd_en_i = 1'b0;
    peek(3'd4, "R5 cleared by read", 0);
    wr(3'd2, 4'b0001); wr(3'd1, 4'b0001);
    cond_i = 4'b0011; step();
    peek(3'd4, "R5 setup event", 1);
    cond_i = 4'b0010; addr_i = 3'd4; rd_en_i = 1'b1;
    step();
    rd_en_i = 1'b0;
    peek(3'd4, "R5 edge wins over read", 1);

    // R7: preset defaults, event untouched, priority over write
    wr(3'd3, 4'd20 & ONES);
    addr_i = 3'd2; wdata_i = 4'd9; wr_en_i = 1'b1; preset_i = 1'b1;
    step();
    wr_en_i = 1'b0; preset_i = 1'b0;
    peek(3'd1, "R7 rise all ones", 15);
    peek(3'd2, "R7 fall cleared over write", 0);
    peek(3'd3, "R7 enable cleared", 0);
    peek(3'd4, "R7 event untouched", 1);

    // R9: weighted value 20 on a wide-enough field (bits 2 and 4 -> low nibble bit 2 only)
    wr(3'd3, 4'b0100);
    peek(3'd3, "R9 weighted 4", 4);

    // R1 R2 R3: sweep every mask pair and flip pattern
    wr(3'd3, ONES);
    for (int up = 0; up < 16; up++) begin
      for (int dn = 0; dn < 16; dn++) begin
        wr(3'd1, 4'(up));
        wr(3'd2, 4'(dn));
        for (int a = 0; a < 16; a++) begin
          logic [W-1:0] b;
          logic [W-1:0] e;
          b = ~4'(a);
          cond_i = 4'(a); step(); step();
          clr_status();
          cond_i = b; step();
          e = expect_hits(4'(a), b, 4'(up), 4'(dn));
          peek(3'd4, "R1 R2 R3 sweep event", int'(e));
          check("R6 sweep summary", int'(summary_o), int'(|e));
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule